// File: doc/BRIEF.md
# Cache-Maintenance Operation Hazard Gate

This block sits in front of the data-cache array in the memory pipeline. It decides whether each cache-maintenance operation (cacheop) may act on the array now, or must wait until the fill/store buffer queue has settled. Every incoming cacheop carries an operation type and a cache index. The block compares that index with the index of every valid buffer entry. The comparison looks at the index alone, so a hit only means that a conflict is possible.

When no valid entry shares the index, the op is accepted at once and buffer activity has no effect on it. A stream of such ops runs at one per clock. When some valid entry shares the index, the op is held with ready low. It stays held while any valid entry still has a cache refill outstanding, or still has a dirty evicted line that has not yet reached the write buffer. The match and the drain state are evaluated again on every cycle, and no stall memory is kept. An accepted op is presented to the cache array on the following cycle. A saturating counter records how many cycles were lost to stalls.

Top module: `cop_hazard_gate`

## Requirements
- R1: After reset, with no op offered: op_ready_o is 1, issue_valid_o is 0 and stall_cnt_o is 0.
- R2: An op whose index equals no valid entry's index is accepted in the cycle it is offered (op_ready_o=1), even while other entries have refills or evictions pending.
- R3: A potential match means a valid entry whose index field (bits [e*IDX_W +: IDX_W] of buf_idx_i for entry e) equals op_idx_i. No other field takes part in the test.
- R4: On a potential match, op_ready_o stays 0 as long as any valid entry has buf_refill_i set. This holds even when that entry is not the matching one.
- R5: On a potential match, op_ready_o also stays 0 as long as any valid entry has buf_evict_i set. Clearing the refill flags alone does not release the op.
- R6: A potential match with no refill and no eviction pending in any valid entry causes no stall.
- R7: An op accepted at a clock edge appears on issue_valid_o, issue_type_o and issue_idx_o in the next cycle. issue_valid_o is 0 in any cycle that follows an edge with no acceptance.
- R8: Ops that do not conflict, offered on consecutive cycles, are all accepted and issued at one per clock with no bubble.
- R9: stall_cnt_o rises by 1 after each edge at which an op was stalled, holds otherwise, and saturates at 2^CNT_W-1.
- R10: The refill and eviction flags of entries with buf_valid_i low have no effect, and an invalid entry with a matching index causes no match.
- R11: The stall decision is made fresh every cycle. An op is released in the cycle its matching entry becomes invalid, and a later op with the same index is not held once the drain conditions are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A cacheop is offered |
| op_type_i | input | OP_W | Operation type, carried through unchanged |
| op_idx_i | input | IDX_W | Cache index of the offered op |
| op_ready_o | output | 1 | Op accepted this cycle; low exactly during stall cycles |
| buf_valid_i | input | N_ENTRIES | Per-entry valid flag of the buffer queue |
| buf_refill_i | input | N_ENTRIES | Per-entry refill-outstanding flag |
| buf_evict_i | input | N_ENTRIES | Per-entry dirty-eviction-not-yet-handed-off flag |
| buf_idx_i | input | N_ENTRIES*IDX_W | Packed per-entry cache indices, entry e at [e*IDX_W +: IDX_W] |
| issue_valid_o | output | 1 | Op presented to the cache array |
| issue_type_o | output | OP_W | Type of the issued op |
| issue_idx_o | output | IDX_W | Index of the issued op |
| stall_cnt_o | output | CNT_W | Saturating count of stalled cycles |

## Verification
A faulty comparator or a faulty drain reduction shows up in the same cycle as a wrong level on op_ready_o. It then shows one edge later as a missing or extra issue_valid_o pulse and as a stall count that is off by one. A broken issue register shows at the first edge after acceptance as a wrong index or type on the issue port. Flags that are wrongly dropped or wrongly kept are exposed by stimulus that clears the refill flags while an eviction is still pending, and by stimulus that invalidates the matching entry during a stall.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_IDX_W   = 7;
  localparam int unsigned DEF_OP_W    = 4;
  localparam int unsigned DEF_CNT_W   = 16;
endpackage

// File: rtl/cop_index_match.sv
module cop_index_match #(
  parameter int unsigned N_ENTRIES = cop_gate_pkg::DEF_ENTRIES,
  parameter int unsigned IDX_W     = cop_gate_pkg::DEF_IDX_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             op_idx_i,
  input  logic [N_ENTRIES-1:0]         buf_valid_i,
  input  logic [N_ENTRIES*IDX_W-1:0]   buf_idx_i,
  output logic                         match_o
);
  logic [N_ENTRIES-1:0] hit;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hit[e] = buf_valid_i[e] && (buf_idx_i[e*IDX_W +: IDX_W] == op_idx_i);
  end

  assign match_o = |hit;

  // R10: a match needs at least one valid entry
  a_r10_match_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (buf_valid_i != '0));
endmodule

// File: rtl/cop_drain_monitor.sv
module cop_drain_monitor #(
  parameter int unsigned N_ENTRIES = cop_gate_pkg::DEF_ENTRIES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] buf_valid_i,
  input  logic [N_ENTRIES-1:0] buf_refill_i,
  input  logic [N_ENTRIES-1:0] buf_evict_i,
  output logic                 busy_o
);
  logic [N_ENTRIES-1:0] refill_live, evict_live;

  assign refill_live = buf_valid_i & buf_refill_i;
  assign evict_live  = buf_valid_i & buf_evict_i;
  assign busy_o      = |(refill_live | evict_live);

  // R4/R5: outstanding work only ever comes from valid entries
  a_r4_busy_from_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (buf_valid_i != '0));
endmodule

// File: rtl/cop_issue_stage.sv
module cop_issue_stage #(
  parameter int unsigned IDX_W = cop_gate_pkg::DEF_IDX_W,
  parameter int unsigned OP_W  = cop_gate_pkg::DEF_OP_W,
  parameter int unsigned CNT_W = cop_gate_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             stall_i,
  input  logic [OP_W-1:0]  op_type_i,
  input  logic [IDX_W-1:0] op_idx_i,
  output logic             issue_valid_o,
  output logic [OP_W-1:0]  issue_type_o,
  output logic [IDX_W-1:0] issue_idx_o,
  output logic [CNT_W-1:0] stall_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_type_o  <= '0;
      issue_idx_o   <= '0;
    end else begin
      issue_valid_o <= accept_i;
      if (accept_i) begin
        issue_type_o <= op_type_i;
        issue_idx_o  <= op_idx_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            stall_cnt_o <= '0;
    else if (stall_i && stall_cnt_o != CNT_MAX) stall_cnt_o <= stall_cnt_o + 1'b1;
  end

  a_r7_issue_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> issue_valid_o && issue_idx_o == $past(op_idx_i) && issue_type_o == $past(op_type_i));
  a_r7_no_spurious_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !issue_valid_o);
  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && stall_cnt_o != CNT_MAX) |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1);
  a_r9_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i || stall_cnt_o == CNT_MAX) |=> $stable(stall_cnt_o));
endmodule

// File: rtl/cop_hazard_gate.sv
module cop_hazard_gate #(
  parameter int unsigned N_ENTRIES = cop_gate_pkg::DEF_ENTRIES,
  parameter int unsigned IDX_W     = cop_gate_pkg::DEF_IDX_W,
  parameter int unsigned OP_W      = cop_gate_pkg::DEF_OP_W,
  parameter int unsigned CNT_W     = cop_gate_pkg::DEF_CNT_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       op_valid_i,
  input  logic [OP_W-1:0]            op_type_i,
  input  logic [IDX_W-1:0]           op_idx_i,
  output logic                       op_ready_o,
  input  logic [N_ENTRIES-1:0]       buf_valid_i,
  input  logic [N_ENTRIES-1:0]       buf_refill_i,
  input  logic [N_ENTRIES-1:0]       buf_evict_i,
  input  logic [N_ENTRIES*IDX_W-1:0] buf_idx_i,
  output logic                       issue_valid_o,
  output logic [OP_W-1:0]            issue_type_o,
  output logic [IDX_W-1:0]           issue_idx_o,
  output logic [CNT_W-1:0]           stall_cnt_o
);
  logic match, busy, stall, accept;

  cop_index_match #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_match (
    .clk_i, .rst_ni, .op_idx_i, .buf_valid_i, .buf_idx_i, .match_o(match)
  );

  cop_drain_monitor #(.N_ENTRIES(N_ENTRIES)) i_drain (
    .clk_i, .rst_ni, .buf_valid_i, .buf_refill_i, .buf_evict_i, .busy_o(busy)
  );

  // stall is recomputed every cycle; nothing about past stalls is stored
  assign stall      = op_valid_i && match && busy;
  assign op_ready_o = !stall;
  assign accept     = op_valid_i && op_ready_o;

  cop_issue_stage #(.IDX_W(IDX_W), .OP_W(OP_W), .CNT_W(CNT_W)) i_issue (
    .clk_i, .rst_ni, .accept_i(accept), .stall_i(stall),
    .op_type_i, .op_idx_i,
    .issue_valid_o, .issue_type_o, .issue_idx_o, .stall_cnt_o
  );

  // R2: ready only drops while an op is offered
  a_r2_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> op_ready_o);
  // R6: no outstanding work means no stall
  a_r6_idle_buffer_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy) |-> op_ready_o);
  // R8: offered op with ready is issued next cycle
  a_r8_one_per_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_ready_o) |=> issue_valid_o);
endmodule

// File: tb/test_cop_hazard_gate.sv
module test_cop_hazard_gate;
  localparam int N = 8;
  localparam int W = 7;
  localparam int OW = 4;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 1'b0;
  logic [OW-1:0] op_type_i = '0;
  logic [W-1:0] op_idx_i = '0;
  logic op_ready_o, issue_valid_o;
  logic [N-1:0] buf_valid_i = '0, buf_refill_i = '0, buf_evict_i = '0;
  logic [N*W-1:0] buf_idx_i = '0;
  logic [OW-1:0] issue_type_o;
  logic [W-1:0] issue_idx_o;
  logic [CW-1:0] stall_cnt_o;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;

  always #5 clk_i = ~clk_i;

  cop_hazard_gate #(.N_ENTRIES(N), .IDX_W(W), .OP_W(OW), .CNT_W(CW)) i_cop_hazard_gate (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_ent(input int e, input bit v, input bit r, input bit d, input int idx);
    buf_valid_i[e] = v;
    buf_refill_i[e] = r;
    buf_evict_i[e] = d;
    buf_idx_i[e*W +: W] = W'(idx);
  endtask

  task automatic clr_buf();
    buf_valid_i = '0; buf_refill_i = '0; buf_evict_i = '0; buf_idx_i = '0;
  endtask

  // offer op, expect immediate acceptance, check issue next cycle
  task automatic pass_op(input string req, input int ty, input int idx);
    op_valid_i = 1'b1; op_type_i = OW'(ty); op_idx_i = W'(idx);
    #1 chk({req, " ready"}, op_ready_o, 1);
    step();
    op_valid_i = 1'b0;
    chk({req, " issue_valid"}, issue_valid_o, 1);
    chk({req, " issue_idx"}, issue_idx_o, idx);
    chk({req, " issue_type"}, issue_type_o, ty);
    chk({req, " stall_cnt"}, stall_cnt_o, exp_cnt);
  endtask

  // one stalled cycle: ready low now, no issue and count+1 after the edge
  task automatic stall_cycle(input string req);
    #1 chk({req, " ready low"}, op_ready_o, 0);
    step();
    if (exp_cnt < CMAX) exp_cnt++;
    chk({req, " no issue"}, issue_valid_o, 0);
    chk({req, " stall_cnt"}, stall_cnt_o, exp_cnt);
  endtask

  task automatic t_reset();
    chk("R1 ready", op_ready_o, 1);
    chk("R1 issue_valid", issue_valid_o, 0);
    chk("R1 stall_cnt", stall_cnt_o, 0);
  endtask

  task automatic t_no_match();
    clr_buf();
    set_ent(0, 1, 1, 0, 5);
    set_ent(1, 1, 0, 1, 7);
    pass_op("R2 no match", 3, 6);
  endtask

  task automatic t_invalid_ignored();
    clr_buf();
    set_ent(2, 0, 1, 1, 6);
    set_ent(3, 1, 0, 0, 6);
    pass_op("R10 invalid entry flags", 2, 6);
    clr_buf();
    set_ent(4, 0, 1, 1, 9);
    set_ent(5, 1, 1, 0, 1);
    pass_op("R10 invalid matching entry", 1, 9);
  endtask

  task automatic t_match_idle();
    clr_buf();
    set_ent(6, 1, 0, 0, 12);
    pass_op("R6 match no pending", 5, 12);
  endtask

  task automatic t_refill_stall();
    clr_buf();
    set_ent(0, 1, 0, 0, 20);
    set_ent(3, 1, 1, 0, 33);
    op_valid_i = 1'b1; op_type_i = 4'd7; op_idx_i = 7'd20;
    for (int i = 0; i < 3; i++) stall_cycle("R4 R3 refill stall");
    buf_refill_i[3] = 1'b0;
    pass_op("R4 release", 7, 20);
  endtask

  task automatic t_evict_stall();
    clr_buf();
    set_ent(1, 1, 0, 0, 40);
    set_ent(2, 1, 1, 0, 41);
    set_ent(4, 1, 0, 1, 42);
    op_valid_i = 1'b1; op_type_i = 4'd9; op_idx_i = 7'd40;
    stall_cycle("R5 both pending");
    buf_refill_i[2] = 1'b0;
    stall_cycle("R5 evict still pending");
    stall_cycle("R5 evict still pending");
    buf_evict_i[4] = 1'b0;
    pass_op("R5 release", 9, 40);
  endtask

  task automatic t_stream();
    clr_buf();
    set_ent(0, 1, 1, 1, 100);
    op_valid_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      op_type_i = OW'(i); op_idx_i = W'(50 + i);
      #1 chk("R8 stream ready", op_ready_o, 1);
      step();
      chk("R8 stream issue_valid", issue_valid_o, 1);
      chk("R8 stream issue_idx", issue_idx_o, 50 + i);
    end
    op_valid_i = 1'b0;
    chk("R8 stream no stall", stall_cnt_o, exp_cnt);
    step();
    chk("R7 idle no issue", issue_valid_o, 0);
  endtask

  task automatic t_no_stale();
    clr_buf();
    set_ent(5, 1, 0, 1, 60);
    op_valid_i = 1'b1; op_type_i = 4'd3; op_idx_i = 7'd60;
    stall_cycle("R11 stall");
    buf_valid_i[5] = 1'b0;
    pass_op("R11 released by invalidate", 3, 60);
    set_ent(5, 1, 0, 0, 60);
    pass_op("R11 same index fresh", 4, 60);
  endtask

  task automatic t_saturate();
    clr_buf();
    set_ent(7, 1, 1, 1, 70);
    op_valid_i = 1'b1; op_type_i = 4'd1; op_idx_i = 7'd70;
    for (int i = 0; i < 20; i++) stall_cycle("R9 saturate");
    chk("R9 saturated value", stall_cnt_o, CMAX);
    clr_buf();
    pass_op("R9 hold after release", 1, 70);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1 t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_match();
    t_invalid_ignored();
    t_match_idle();
    t_refill_stall();
    t_evict_stall();
    t_stream();
    t_no_stale();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule